// File: doc/BRIEF.md
# Serial DAC Write Controller

This block takes a 12-bit sample from a host through a valid/ready handshake and plays it out over a three-wire serial converter link. The three wires are a data line, a shift clock and an active-low load strobe. The bits go out most significant first. Each bit is placed on the data line while the shift clock is low, and the receiver captures it on the rising edge of the shift clock. After the twelfth bit, the load strobe is pulsed low so that the receiver copies its input shift register into its output register in parallel.

Every timing phase is counted in system clock cycles and set by a parameter. This lets one netlist meet the receiver's minimum setup, hold, clock-high, clock-low and load-pulse widths at any system clock rate. A mode input can flip the top data bit before shifting, which turns a two's complement sample into the offset binary code that a bipolar output stage needs. When the strobe returns high, a one-cycle done pulse marks the end of the write.

Top module: `serial_dac_writer`

## Requirements
- R1: Each accepted request produces exactly 12 rising edges of `dac_sclk`. The bit on `dac_sdata` at the k-th rising edge is bit (12-k) of the coded word, so bit 11 goes first and bit 0 goes last.
- R2: Before each rising edge, `dac_sdata` holds its value and `dac_sclk` stays low for at least max(SETUP_CYC, CLK_LO_CYC) system cycles.
- R3: `dac_sclk` stays high for at least max(CLK_HI_CYC, HOLD_CYC) cycles, and `dac_sdata` does not change while `dac_sclk` is high.
- R4: After the twelfth falling edge, `dac_load_n` goes low at once for at least LOAD_CYC cycles. `dac_sclk` stays low for the whole pulse.
- R5: Only `in_word[11:0]` is used. `in_word[15:12]` has no effect on the bits shifted out.
- R6: With `twos_comp`=1 the shifted word is {~in_word[11], in_word[10:0]}. With `twos_comp`=0 it is in_word[11:0]. The mode is sampled in the cycle the request is accepted.
- R7: A request is accepted in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high only when idle. It stays low from acceptance until `dac_load_n` has returned high, and a valid held during a transfer starts no further transfer.
- R8: During and after reset, `dac_sclk`=0, `dac_load_n`=1, `in_ready`=1 and `done`=0. At idle, `dac_sdata` keeps the last bit it sent.
- R9: `done` is high for exactly one cycle, the cycle in which `dac_load_n` returns high, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host request strobe |
| in_ready | output | 1 | Block idle and able to accept a word |
| in_word | input | 16 | Right-justified sample; the upper 4 bits are ignored |
| twos_comp | input | 1 | 1: invert the top data bit (two's complement to offset binary) |
| dac_sdata | output | 1 | Serial data to the converter |
| dac_sclk | output | 1 | Shift clock; the receiver samples on its rising edge |
| dac_load_n | output | 1 | Active-low transfer strobe |
| done | output | 1 | One-cycle pulse at the end of a write |

## Verification
The bench places a receiver model on the three wires. It measures every low, high and strobe phase in cycles, so a counter that is off by one shows up as a phase that is one cycle too short. It also catches data that changes while the clock is high, which a design that shifts on the wrong edge would produce. Words whose top nibble is random, or set to all ones, would expose a design that sends bits 15..4 or puts the word in the wrong place in the shift register. Both modes are run with the top data bit at 0 and at 1, so that flipping the wrong bit shows up, and a valid held high across a whole transfer would expose a design that lets `in_ready` rise early or accepts a second word.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOAD = 2'd3
    } phase_e;

    function automatic int max_cyc(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/dacw_phase_timer.sv
module dacw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign expired = (count == '0);

    // R2, R3, R4: a phase length never shortens once it has been loaded
    a_r2_steady_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/dacw_bit_shifter.sv
module dacw_bit_shifter #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    localparam int IDX_W = dacw_pkg::cnt_bits(WORD_W - 1);

    logic [WORD_W-1:0] sr;
    logic [IDX_W-1:0]  remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            remaining <= '0;
        end else if (load) begin
            sr        <= word;
            remaining <= IDX_W'(WORD_W - 1);
        end else if (shift) begin
            sr        <= {sr[WORD_W-2:0], 1'b0};
            remaining <= remaining - 1'b1;
        end
    end

    assign msb  = sr[WORD_W-1];
    assign last = (remaining == '0);

    // R1: no shift is asked for once the last bit is on the line
    a_r1_no_extra_shift: assert property (@(posedge clk) disable iff (rst)
        shift |-> !last);

endmodule

// File: rtl/serial_dac_writer.sv
module serial_dac_writer #(
    parameter int IN_W       = 16,
    parameter int WORD_W     = 12,
    parameter int SETUP_CYC  = 4,
    parameter int HOLD_CYC   = 8,
    parameter int CLK_HI_CYC = 9,
    parameter int CLK_LO_CYC = 12,
    parameter int LOAD_CYC   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IN_W-1:0] in_word,
    input  logic            twos_comp,
    output logic            dac_sdata,
    output logic            dac_sclk,
    output logic            dac_load_n,
    output logic            done
);
    import dacw_pkg::*;

    localparam int LO_CYC = max_cyc(SETUP_CYC, CLK_LO_CYC);
    localparam int HI_CYC = max_cyc(HOLD_CYC, CLK_HI_CYC);
    localparam int CNT_W  = cnt_bits(max_cyc(max_cyc(LO_CYC, HI_CYC), LOAD_CYC));

    phase_e            phase;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              expired;
    logic              sh_load;
    logic              sh_shift;
    logic              sh_last;
    logic [WORD_W-1:0] coded;

    assign in_ready = (phase == PH_IDLE);
    assign accept   = in_valid && in_ready;
    assign coded    = {in_word[WORD_W-1] ^ twos_comp, in_word[WORD_W-2:0]};

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        case (phase)
            PH_IDLE: if (accept) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(LO_CYC - 1);
                sh_load  = 1'b1;
            end
            PH_LOW: if (expired) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HI_CYC - 1);
            end
            PH_HIGH: if (expired) begin
                tmr_load = 1'b1;
                if (sh_last) begin
                    tmr_val = CNT_W'(LOAD_CYC - 1);
                end else begin
                    tmr_val  = CNT_W'(LO_CYC - 1);
                    sh_shift = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            dac_sclk   <= 1'b0;
            dac_load_n <= 1'b1;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (accept) phase <= PH_LOW;
                PH_LOW: if (expired) begin
                    phase    <= PH_HIGH;
                    dac_sclk <= 1'b1;
                end
                PH_HIGH: if (expired) begin
                    dac_sclk <= 1'b0;
                    if (sh_last) begin
                        phase      <= PH_LOAD;
                        dac_load_n <= 1'b0;
                    end else begin
                        phase <= PH_LOW;
                    end
                end
                PH_LOAD: if (expired) begin
                    phase      <= PH_IDLE;
                    dac_load_n <= 1'b1;
                    done       <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    dacw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    dacw_bit_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .word(coded), .shift(sh_shift),
        .msb(dac_sdata), .last(sh_last)
    );

    a_r3_data_held_high: assert property (@(posedge clk) disable iff (rst)
        dac_sclk |-> $stable(dac_sdata));

    a_r4_clock_low_in_load: assert property (@(posedge clk) disable iff (rst)
        !dac_load_n |-> !dac_sclk);

    a_r7_busy_through_load: assert property (@(posedge clk) disable iff (rst)
        (!dac_load_n || dac_sclk) |-> !in_ready);

    a_r9_done_on_strobe_end: assert property (@(posedge clk) disable iff (rst)
        done |-> (dac_load_n && !$past(dac_load_n)));

    a_r8_strobe_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (dac_load_n && !dac_sclk));

endmodule

// File: tb/serial_dac_writer_test.sv
module serial_dac_writer_test;
    localparam int SETUP_CYC = 4, HOLD_CYC = 8, CLK_HI_CYC = 9, CLK_LO_CYC = 12, LOAD_CYC = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, twos_comp = 1'b0;
    logic [15:0] in_word = '0;
    logic in_ready, dac_sdata, dac_sclk, dac_load_n, done;

    int compared = 0, mismatched = 0;

    always #5 clk = ~clk;

    serial_dac_writer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .twos_comp(twos_comp), .dac_sdata(dac_sdata),
        .dac_sclk(dac_sclk), .dac_load_n(dac_load_n), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] expect_word(input logic [15:0] w, input logic tc);
        return {w[11] ^ tc, w[10:0]};
    endfunction

    // receiver model, sampled away from the active edge
    logic [11:0] rx_word = '0;
    int rx_bits = 0, loads = 0;
    int data_age = 0, low_run = 0, high_run = 0, ld_run = 0;
    logic prev_sclk = 1'b0, prev_ld = 1'b1, prev_sd = 1'b0;
    bit busy = 0;
    logic [11:0] exp_word = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = dac_sclk; prev_ld = dac_load_n; prev_sd = dac_sdata;
            data_age = 0; low_run = 0; high_run = 0; ld_run = 0;
        end else begin
            if (dac_sclk && !prev_sclk) begin
                check(data_age >= SETUP_CYC && low_run >= CLK_LO_CYC, "R2 setup/low",
                      (data_age < low_run) ? data_age : low_run, CLK_LO_CYC);
                rx_word = {rx_word[10:0], dac_sdata};
                rx_bits++;
            end
            if (!dac_sclk && prev_sclk)
                check(high_run >= CLK_HI_CYC && high_run >= HOLD_CYC, "R3 high width",
                      high_run, CLK_HI_CYC);
            if (dac_sclk && prev_sclk && dac_sdata != prev_sd)
                check(0, "R3 data moved while clock high", dac_sdata, prev_sd);
            if (!dac_load_n && prev_ld) begin
                check(rx_bits == 12, "R1 bit count before strobe", rx_bits, 12);
                check(!dac_sclk, "R4 clock low at strobe", dac_sclk, 0);
            end
            if (dac_load_n && !prev_ld) begin
                check(ld_run >= LOAD_CYC, "R4 strobe width", ld_run, LOAD_CYC);
                check(rx_word == exp_word, "R1/R5/R6 received word", rx_word, exp_word);
                check(done == 1'b1, "R9 done at strobe end", done, 1);
                loads++;
                rx_bits = 0;
                busy = 0;
            end else if (done)
                check(0, "R9 stray done", done, 0);
            if (busy && dac_load_n == prev_ld && in_ready)
                check(0, "R7 ready high during transfer", in_ready, 0);
            data_age = (dac_sdata == prev_sd) ? data_age + 1 : 1;
            low_run  = dac_sclk ? 0 : low_run + 1;
            high_run = dac_sclk ? high_run + 1 : 0;
            ld_run   = dac_load_n ? 0 : ld_run + 1;
            prev_sclk = dac_sclk; prev_ld = dac_load_n; prev_sd = dac_sdata;
        end
    end

    task automatic send(input logic [15:0] w, input logic tc, input int hold_extra);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_word = w; twos_comp = tc;
        exp_word = expect_word(w, tc);
        @(negedge clk);
        busy = 1;
        in_word = ~w; twos_comp = ~tc;
        repeat (hold_extra) @(negedge clk);
        in_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int l0;
        void'($urandom(32'h5EED_0043));
        repeat (3) @(negedge clk);
        // R8 reset state
        check(dac_sclk == 0 && dac_load_n == 1 && in_ready == 1 && done == 0,
              "R8 reset outputs", {dac_sclk, dac_load_n, in_ready, done}, 4'b0110);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        check(in_ready == 1 && dac_load_n == 1, "R8 idle after reset", in_ready, 1);

        // directed: R1 order, R5 upper nibble ignored, R6 both modes/both MSBs
        send(16'hFA5C, 1'b0, 0);
        send(16'h0A5C, 1'b1, 0);
        send(16'hF3A1, 1'b1, 0);
        send(16'h0800, 1'b0, 0);
        send(16'hF7FF, 1'b1, 0);
        send(16'h0001, 1'b0, 0);
        // R8 data line holds last bit (bit 0 of 0x001 = 1)
        repeat (20) @(negedge clk);
        check(dac_sdata == 1'b1 && dac_sclk == 0, "R8 data held at idle", dac_sdata, 1);

        // R7 valid held well into the transfer: one load only
        l0 = loads;
        send(16'h0ABC, 1'b0, 100);
        repeat (30) @(negedge clk);
        check(loads == l0 + 1, "R7 single acceptance", loads - l0, 1);
        check(in_ready == 1, "R7 ready back at idle", in_ready, 1);

        // random mix
        for (int i = 0; i < 50; i++)
            send(16'($urandom), 1'($urandom), int'($urandom_range(0, 3)));

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule